// File: doc/BRIEF.md
# E3 Overhead Insertion Sequencer

This block sits beside an E3 framer, on the terminal-equipment side of the framer's transmit overhead input port. On every rising edge of the E3 clock it looks at two strobes from the framer. One is a frame marker. The other is an overhead-enable strobe, which says the framer is about to take an overhead bit. When both are high together, that sample is the first overhead bit of a new frame. After that, each enable-high sample moves to the next overhead bit. The block never times the overhead positions itself. It finds the current bit only by counting enable strobes.

The frame carries seven overhead bytes. That gives 56 bit slots, each byte sent most significant bit first. Slot 0 is the most significant bit of byte 0, and slot 55 is the least significant bit of byte 6. A host loads a value byte and a per-bit insert mask for each overhead byte through a small write port. The block raises the insert request, with the chosen bit value, in each enable slot whose mask bit is set. The two framing bytes (slots 0 to 15) are never replaced.

Host writes go to a shadow copy. The shadow copy moves into the working copy only at a frame start, so no frame carries a mix of old and new content. The block inserts nothing until it has seen a frame start. If enable strobes run past slot 55 with no frame start, it sets a sticky error flag, stops inserting and waits for the next frame start.

Top module: `e3_ohins_seq`

## Requirements
- R1: After reset, `oh_ins`, `oh_bit` and `sync_err` are 0. No insert request is made on any enable strobe until the first sample with `tx_frm_mark` and `tx_oh_en` both high.
- R2: A sample with `tx_frm_mark` and `tx_oh_en` both high is slot 0. Each later sample with `tx_oh_en` high advances the slot by one. Samples with `tx_oh_en` low do not advance the slot.
- R3: Slot s carries bit (7 - s mod 8) of overhead byte s/8. Byte indices 0 to 6 are selected by `host_idx`, so each byte is sent most significant bit first.
- R4: `oh_ins` is high in the same cycle as a `tx_oh_en`-high sample exactly when the block is synchronised, the slot is between 16 and 55, and the working mask bit for that slot is 1.
- R5: While `oh_ins` is high, `oh_bit` equals the working value bit for that slot. Otherwise `oh_bit` is 0.
- R6: Slots 0 to 15 (bytes 0 and 1) never raise `oh_ins`, even when their mask bits are 1.
- R7: A host write (`host_wr` = 1) stores `host_byte` in the shadow value register (`host_sel` = 0) or the shadow mask register (`host_sel` = 1) of byte `host_idx`. The write affects outputs only from the next frame start onward.
- R8: If a `tx_oh_en`-high sample arrives while the slot count stands at 56 with no frame start, `sync_err` goes high on the next cycle and stays high until reset. From that sample on, no insert is made until the next frame start, after which insertion resumes.
- R9: A write with `host_idx` of 7 or more changes no register, so the outputs of every later frame are unchanged by it.
- R10: A sample with `tx_frm_mark` high and `tx_oh_en` low neither restarts nor advances the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E3 clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_frm_mark | input | 1 | Frame marker strobe from the framer |
| tx_oh_en | input | 1 | Overhead-enable strobe from the framer |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the value byte, 1 selects the mask byte |
| host_idx | input | 3 | Overhead byte index, 0 to 6 |
| host_byte | input | 8 | Byte to be written |
| oh_ins | output | 1 | Insert request to the framer |
| oh_bit | output | 1 | Overhead bit value to insert |
| sync_err | output | 1 | Sticky flag for enable strobes past the last slot |

## Verification
The tests use four kinds of frame.

1. Frames where every mask bit is set, with enable strobes padded by idle cycles. These show that only enable-high samples advance the slot, and that every value bit lands in its MSB-first position.
2. A frame that receives host writes, stray frame markers without enable, and a write to an invalid index partway through. This frame and the one after it show the difference between the shadow copy and the working copy, and that markers without enable are ignored.
3. A sparse mask pattern, which shows per-bit gating separately from the value bits.
4. A run of strobes past slot 55, which separates loss of synchronisation and the sticky flag from the resynchronisation at the next frame start.

// File: rtl/e3oh_pkg.sv
// Package: shared constants and types for the E3 overhead insertion sequencer.
// Assumes: the frame carries a whole number of 8-bit overhead bytes.
package e3oh_pkg;
    localparam int unsigned OH_BYTES_DEF   = 7;
    localparam int unsigned OH_BYTE_W_DEF  = 8;
    localparam int unsigned OH_BLOCKED_DEF = 16;

    // host register selector
    typedef enum logic {
        SEL_VALUE = 1'b0,
        SEL_MASK  = 1'b1
    } e3oh_sel_e;
endpackage

// File: rtl/e3oh_regbank.sv
// Module: shadow and working copies of the overhead value and mask bytes.
// Host writes land in the shadow copy. The whole shadow copy moves to the
// working copy on the load strobe (a frame start).
// Outputs are flattened to one bit per slot, MSB of byte 0 in slot 0.
// Assumes: a write in the same cycle as load reaches the working copy one frame later.
module e3oh_regbank
    import e3oh_pkg::*;
#(
    parameter int unsigned N_BYTES = OH_BYTES_DEF,
    parameter int unsigned BYTE_W  = OH_BYTE_W_DEF,
    localparam int unsigned N_SLOTS = N_BYTES * BYTE_W,
    localparam int unsigned IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES + 1) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                sel,
    input  logic [IDX_W-1:0]    idx,
    input  logic [BYTE_W-1:0]   wbyte,
    input  logic                load,
    output logic [N_SLOTS-1:0]  val_flat,
    output logic [N_SLOTS-1:0]  msk_flat
);
    logic [BYTE_W-1:0] shd_val [N_BYTES];
    logic [BYTE_W-1:0] shd_msk [N_BYTES];
    logic [BYTE_W-1:0] act_val [N_BYTES];
    logic [BYTE_W-1:0] act_msk [N_BYTES];

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        logic hit;
        assign hit = wr && (idx == IDX_W'(b));

        // shadow update from the host port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd_val[b] <= '0;
                shd_msk[b] <= '0;
            end else if (hit) begin
                if (sel == SEL_MASK) shd_msk[b] <= wbyte;
                else                 shd_val[b] <= wbyte;
            end
        end

        // working copy refreshed at each frame start
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_val[b] <= '0;
                act_msk[b] <= '0;
            end else if (load) begin
                act_val[b] <= shd_val[b];
                act_msk[b] <= shd_msk[b];
            end
        end

        for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
            // slot order: MSB first within each byte
            assign val_flat[b*BYTE_W + k] = act_val[b][BYTE_W-1-k];
            assign msk_flat[b*BYTE_W + k] = act_msk[b][BYTE_W-1-k];
        end
    end

    // R7
    working_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(val_flat) && $stable(msk_flat)));
endmodule

// File: rtl/e3oh_slot_tracker.sv
// Module: recovers the current overhead slot from the framer strobes.
// A coincident marker-and-enable sample is slot 0. Each later enable
// sample advances the count. An enable sample at count N_SLOTS drops
// sync and sets a sticky error.
// Assumes: strobes are synchronous to clk.
module e3oh_slot_tracker #(
    parameter int unsigned N_SLOTS = 56,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm,
    input  logic              en,
    output logic              start,
    output logic [SLOT_W-1:0] slot,
    output logic              live,
    output logic              err
);
    localparam logic [SLOT_W-1:0] END_CNT = SLOT_W'(N_SLOTS);

    logic [SLOT_W-1:0] cnt;
    logic              synced;

    // frame start and current slot decode
    always_comb begin
        start = frm && en;
        slot  = start ? '0 : cnt;
        live  = start || (synced && (cnt != END_CNT));
    end

    // slot counter, sync state and sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            synced <= 1'b0;
            err    <= 1'b0;
        end else if (start) begin
            cnt    <= SLOT_W'(1);
            synced <= 1'b1;
        end else if (en && synced) begin
            if (cnt == END_CNT) begin
                synced <= 1'b0;
                err    <= 1'b1;
            end else begin
                cnt <= cnt + SLOT_W'(1);
            end
        end
    end

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm && en) |=> (synced && cnt == SLOT_W'(1)));
    // R10
    stray_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm && !en) |=> ($stable(cnt) && $stable(synced)));
    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !frm && synced && cnt == END_CNT) |=> (err && !synced));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/e3oh_bit_select.sv
// Module: picks the mask and value bit for the current slot and drives
// the insert request. Slots below N_BLOCKED are always refused.
// Assumes: slot may exceed N_SLOTS-1, so the vectors are zero padded.
module e3oh_bit_select #(
    parameter int unsigned N_SLOTS   = 56,
    parameter int unsigned N_BLOCKED = 16,
    localparam int unsigned SLOT_W   = $clog2(N_SLOTS + 1),
    localparam int unsigned PAD_N    = 1 << SLOT_W
) (
    input  logic               en,
    input  logic               live,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [N_SLOTS-1:0] val_flat,
    input  logic [N_SLOTS-1:0] msk_flat,
    output logic               ins,
    output logic               ins_bit
);
    logic [PAD_N-1:0] val_pad;
    logic [PAD_N-1:0] msk_pad;
    logic             blocked;

    // gate the insert request and its data bit
    always_comb begin
        val_pad = {{(PAD_N - N_SLOTS){1'b0}}, val_flat};
        msk_pad = {{(PAD_N - N_SLOTS){1'b0}}, msk_flat};
        blocked = (32'(slot) < N_BLOCKED);
        ins     = en && live && !blocked && msk_pad[slot];
        ins_bit = ins && val_pad[slot];
    end
endmodule

// File: rtl/e3_ohins_seq.sv
// Module: E3 overhead insertion sequencer top.
// It samples the framer's frame marker and overhead enable, tracks the
// overhead slot and requests insertion of host-chosen bits.
// Assumes: insert request and data are presented in the same cycle as
// the enable sample they answer.
module e3_ohins_seq
    import e3oh_pkg::*;
#(
    parameter int unsigned N_BYTES   = OH_BYTES_DEF,
    parameter int unsigned BYTE_W    = OH_BYTE_W_DEF,
    parameter int unsigned N_BLOCKED = OH_BLOCKED_DEF,
    localparam int unsigned N_SLOTS  = N_BYTES * BYTE_W,
    localparam int unsigned SLOT_W   = $clog2(N_SLOTS + 1),
    localparam int unsigned IDX_W    = (N_BYTES > 1) ? $clog2(N_BYTES + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_frm_mark,
    input  logic              tx_oh_en,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [BYTE_W-1:0] host_byte,
    output logic              oh_ins,
    output logic              oh_bit,
    output logic              sync_err
);
    logic               start;
    logic               live;
    logic [SLOT_W-1:0]  slot;
    logic [N_SLOTS-1:0] val_flat;
    logic [N_SLOTS-1:0] msk_flat;

    e3oh_slot_tracker #(.N_SLOTS(N_SLOTS)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .frm   (tx_frm_mark),
        .en    (tx_oh_en),
        .start (start),
        .slot  (slot),
        .live  (live),
        .err   (sync_err)
    );

    e3oh_regbank #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .sel      (host_sel),
        .idx      (host_idx),
        .wbyte    (host_byte),
        .load     (start),
        .val_flat (val_flat),
        .msk_flat (msk_flat)
    );

    e3oh_bit_select #(.N_SLOTS(N_SLOTS), .N_BLOCKED(N_BLOCKED)) u_sel (
        .en       (tx_oh_en),
        .live     (live),
        .slot     (slot),
        .val_flat (val_flat),
        .msk_flat (msk_flat),
        .ins      (oh_ins),
        .ins_bit  (oh_bit)
    );

    // R4
    ins_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oh_ins |-> tx_oh_en);
    // R5
    bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oh_ins |-> !oh_bit);
    // R6
    no_ins_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frm_mark && tx_oh_en) |-> !oh_ins);
endmodule

// File: tb/test_e3_ohins_seq.sv
// Scoreboard bench: the step task drives one cycle and queues the
// expected outputs; the monitor pops and compares them mid-cycle.
module test_e3_ohins_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_frm_mark = 1'b0, tx_oh_en = 1'b0;
    logic       host_wr = 1'b0, host_sel = 1'b0;
    logic [2:0] host_idx = '0;
    logic [7:0] host_byte = '0;
    logic       oh_ins, oh_bit, sync_err;

    always #4 clk = ~clk;

    e3_ohins_seq i_e3_ohins_seq (
        .clk(clk), .rst_n(rst_n), .tx_frm_mark(tx_frm_mark), .tx_oh_en(tx_oh_en),
        .host_wr(host_wr), .host_sel(host_sel), .host_idx(host_idx),
        .host_byte(host_byte), .oh_ins(oh_ins), .oh_bit(oh_bit), .sync_err(sync_err)
    );

    typedef struct {
        logic  ins;
        logic  dbit;
        logic  err;
        string tag;
    } exp_t;
    exp_t q[$];

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model built from the requirements
    logic [7:0] m_sv [7], m_sm [7], m_av [7], m_am [7];
    bit m_sync = 0, m_err = 0;
    int m_cnt = 0;

    task automatic step(input bit frm, input bit en, input bit hw, input bit hs,
                        input int hi, input logic [7:0] hb, input string tag);
        exp_t e;
        int s;
        bit st;
        @(negedge clk);
        tx_frm_mark = frm; tx_oh_en = en; host_wr = hw; host_sel = hs;
        host_idx = 3'(hi); host_byte = hb;
        st = frm && en;
        s  = st ? 0 : m_cnt;
        e.ins  = en && (st || m_sync) && s >= 16 && s < 56 && m_am[s/8][7 - s%8];
        e.dbit = e.ins && m_av[s/8][7 - s%8];
        e.err  = m_err;
        if (tag == "") e.tag = (en && s < 16) ? "R6" : "R4";
        else e.tag = tag;
        q.push_back(e);
        if (st) begin
            m_sync = 1; m_cnt = 1;
            for (int b = 0; b < 7; b++) begin m_av[b] = m_sv[b]; m_am[b] = m_sm[b]; end
        end else if (en && m_sync) begin
            if (m_cnt == 56) begin m_sync = 0; m_err = 1; end
            else m_cnt++;
        end
        if (hw && hi < 7) begin
            if (hs) m_sm[hi] = hb; else m_sv[hi] = hb;
        end
    endtask

    task automatic hwrite(input bit hs, input int hi, input logic [7:0] hb, input string tag);
        step(0, 0, 1, hs, hi, hb, tag);
    endtask

    task automatic pulses(input int n, input int gap_every, input string tag);
        for (int k = 1; k <= n; k++) begin
            step(0, 1, 0, 0, 0, 8'h00, tag);
            if (gap_every > 0 && k % gap_every == 0) step(0, 0, 0, 0, 0, 8'h00, "R2");
        end
    endtask

    // monitor: compare outputs mid-cycle against the queue
    always @(negedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (oh_ins !== e.ins || oh_bit !== e.dbit || sync_err !== e.err) begin
                errors++;
                $display("FAIL %s: ins/bit/err actual=%b%b%b expected=%b%b%b at %0t",
                         e.tag, oh_ins, oh_bit, sync_err, e.ins, e.dbit, e.err, $time);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 7; b++) begin m_sv[b] = 0; m_sm[b] = 0; m_av[b] = 0; m_am[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset, then unsynchronised strobes with masks set
        step(0, 0, 0, 0, 0, 8'h00, "R1");
        for (int b = 0; b < 7; b++) hwrite(1, b, 8'hFF, "R1");
        for (int b = 0; b < 7; b++) hwrite(0, b, 8'h3C ^ 8'(b * 8'h27), "R1");
        pulses(20, 0, "R1");
        // R2 R3: full mask frame with idle gaps
        step(1, 1, 0, 0, 0, 8'h00, "R2");
        pulses(55, 4, "R3");
        // R7 R9 R10: mid-frame writes, stray marker, bad index
        step(1, 1, 0, 0, 0, 8'h00, "R2");
        pulses(20, 0, "");
        step(1, 0, 0, 0, 0, 8'h00, "R10");
        hwrite(0, 4, 8'hC3, "R7");
        hwrite(1, 5, 8'h5A, "R7");
        hwrite(0, 7, 8'h00, "R9");
        hwrite(1, 7, 8'h00, "R9");
        pulses(35, 0, "R7");
        step(1, 1, 0, 0, 0, 8'h00, "R2");
        pulses(55, 0, "R7");
        // R4 R5 R6: sparse masks including framing bytes
        hwrite(1, 0, 8'hFF, "R6");
        hwrite(1, 2, 8'hA5, "R4");
        hwrite(1, 3, 8'h0F, "R4");
        hwrite(1, 6, 8'h81, "R5");
        step(1, 1, 0, 0, 0, 8'h00, "R2");
        pulses(55, 5, "");
        // R8: overrun, sticky flag, resync
        step(1, 1, 0, 0, 0, 8'h00, "R2");
        pulses(55, 0, "");
        pulses(6, 0, "R8");
        step(0, 0, 0, 0, 0, 8'h00, "R8");
        step(1, 1, 0, 0, 0, 8'h00, "R8");
        pulses(55, 0, "R8");
        step(0, 0, 0, 0, 0, 8'h00, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule